// File: doc/BRIEF.md
# Ring Node Pass-Through, Receive Steering and Orphan Scrubber

This block sits in one node of a unidirectional symbol ring. Packets arrive on an inbound stream one symbol per beat, the first symbol being the header. The header's low 16 bits name the destination node. The block compares that field against the node range this node owns, which is given by a base ID and a mask. Packets it owns go into a receive queue that drains through the `rx_*` stream. All other packets are copied through a small pass-through FIFO to the outbound stream. Packets built locally on the `ins_*` stream get onto the ring only when nothing else is passing through, so a packet on the ring is never cut in two.

Exactly one node on a ring is set up as scrubber, chosen by the `scrub_en` input. That node sets a reserved flag bit in the header of every packet it forwards. A forwarded packet that comes back to it with the flag already set has gone round once without finding an owner, and it is removed. Two saturating counters report removed orphans and packets refused because the receive queue lacked room.

All three data interfaces are valid/ready streams. A beat moves when valid and ready are both high. A source that raises valid keeps valid, data and last unchanged until the beat is taken. The block follows the same rule on `out_*` and `rx_*`. `in_ready` depends on where the current packet is going: pass-through packets stall while the FIFO is full, and owned packets stall while the receive queue is full. Packets being removed or refused are always accepted.

Top module: `ring_node_bypass`

## Requirements
- R1: During and right after reset `out_valid`, `rx_valid` and `ins_ready` are low and both drop counters read zero.
- R2: A header is owned by this node when `((hdr[15:0] ^ node_base) & node_mask) == 0`; ownership is decided on the header beat and applies to every beat up to and including the one with `last` high.
- R3: An owned packet whose header finds at least MAX_PKT free receive-queue entries is delivered on `rx_*` unchanged and in arrival order, with `rx_data`/`rx_last` held while `rx_ready` is low.
- R4: A packet that is not owned and not removed leaves on `out_*` in arrival order, at the earliest one cycle after it is accepted, with every non-header beat unchanged.
- R5: An owned packet whose header finds fewer than MAX_PKT free receive-queue entries is accepted and discarded in full, and `drop_full_cnt` rises by one.
- R6: With `scrub_en` high, bit 16 of every forwarded header is set on `out_data`.
- R7: With `scrub_en` high, a packet that is not owned and arrives with header bit 16 set is accepted and discarded in full, and `drop_mark_cnt` rises by one.
- R8: With `scrub_en` low, header bit 16 passes unchanged and packets with it set are forwarded like any other.
- R9: A local packet may begin on `out_*` only when the pass-through FIFO is empty and no forwarded packet is part-way through arriving; once offered it keeps the outbound stream until its last beat, with no forwarded beat mixed in.
- R10: `in_ready` is low only while the current packet goes to a full pass-through FIFO or a full receive queue; `out_data`/`out_last` stay stable while `out_valid` is high and `out_ready` low.
- R11: Both drop counters saturate at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| node_base | input | NODE_W | Base node ID of the owned range |
| node_mask | input | NODE_W | Bits of the node ID that are compared |
| scrub_en | input | 1 | This node is the ring scrubber |
| in_valid | input | 1 | Inbound ring beat valid |
| in_ready | output | 1 | Inbound ring beat accepted |
| in_data | input | SYM_W | Inbound ring symbol |
| in_last | input | 1 | Final beat of inbound packet |
| ins_valid | input | 1 | Local packet beat valid |
| ins_ready | output | 1 | Local packet beat accepted |
| ins_data | input | SYM_W | Local packet symbol |
| ins_last | input | 1 | Final beat of local packet |
| out_valid | output | 1 | Outbound ring beat valid |
| out_ready | input | 1 | Downstream takes outbound beat |
| out_data | output | SYM_W | Outbound ring symbol |
| out_last | output | 1 | Final beat of outbound packet |
| rx_valid | output | 1 | Receive beat valid |
| rx_ready | input | 1 | Consumer takes receive beat |
| rx_data | output | SYM_W | Received symbol |
| rx_last | output | 1 | Final beat of received packet |
| drop_mark_cnt | output | CNT_W | Orphans removed by the scrubber |
| drop_full_cnt | output | CNT_W | Owned packets refused for lack of room |

## Verification
Owned and foreign destinations are mixed first with both outbound and receive consumers always ready. This separates decode and ordering errors from flow-control errors. The same mix is then run with random stalls on `out_ready` and `rx_ready` while local packets compete for the link, so faults in insertion gating, interleaving and hold-under-stall show up cycle by cycle against a behavioural model. With the receive consumer stopped, a stream of owned packets fills the queue: this exposes an off-by-one room test and, later, counter saturation. The scrubber runs with marked and unmarked foreign packets and a marked owned one, to tell marking, removal and ownership priority apart, and the marked packets are replayed with scrubbing off.

// File: rtl/ring_node_pkg.sv
package ring_node_pkg;
  typedef enum logic [1:0] {
    RT_PASS = 2'd0,
    RT_OWN  = 2'd1,
    RT_KILL = 2'd2,
    RT_FULL = 2'd3
  } route_e;
endpackage

// File: rtl/ring_sym_fifo.sv
module ring_sym_fifo #(
  parameter int W     = 25,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (int'(count) == DEPTH);
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_en && !full) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_en && !full) wp <= nxt(wp);
      if (rd_en && !empty) rp <= nxt(rp);
      case ({wr_en && !full, rd_en && !empty})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ring_sat_cnt.sv
module ring_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bump,
  output logic [W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 value <= '0;
    else if (bump && !(&value)) value <= value + 1'b1;
  end
endmodule

// File: rtl/ring_route_ctl.sv
module ring_route_ctl
  import ring_node_pkg::*;
#(
  parameter int SYM_W    = 24,
  parameter int NODE_W   = 16,
  parameter int RX_DEPTH = 16,
  parameter int MAX_PKT  = 4,
  localparam int RCW     = $clog2(RX_DEPTH + 1),
  localparam int FLAG    = NODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NODE_W-1:0] node_base,
  input  logic [NODE_W-1:0] node_mask,
  input  logic              scrub_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SYM_W-1:0]  in_data,
  input  logic              in_last,
  input  logic              pass_full,
  input  logic              own_full,
  input  logic [RCW-1:0]    own_count,
  output logic              pass_wr,
  output logic              own_wr,
  output logic [SYM_W:0]    beat_out,
  output logic              pass_mid,
  output logic              kill_evt,
  output logic              full_evt
);
  logic   mid_q;
  route_e route_q, hdr_route, cur_route;
  logic   owned, flagged, room, fire;
  logic [SYM_W-1:0] sym;

  assign owned   = (((in_data[NODE_W-1:0] ^ node_base) & node_mask) == '0);
  assign flagged = in_data[FLAG];
  assign room    = (RX_DEPTH - int'(own_count)) >= MAX_PKT;

  always_comb begin
    if (owned)                    hdr_route = room ? RT_OWN : RT_FULL;
    else if (scrub_en && flagged) hdr_route = RT_KILL;
    else                          hdr_route = RT_PASS;
  end

  assign cur_route = mid_q ? route_q : hdr_route;

  always_comb begin
    case (cur_route)
      RT_PASS: in_ready = !pass_full;
      RT_OWN:  in_ready = !own_full;
      default: in_ready = 1'b1;
    endcase
  end

  assign fire = in_valid && in_ready;

  always_comb begin
    sym = in_data;
    if (!mid_q && scrub_en) sym[FLAG] = 1'b1;
  end

  assign beat_out = {in_last, (cur_route == RT_PASS) ? sym : in_data};
  assign pass_wr  = fire && (cur_route == RT_PASS);
  assign own_wr   = fire && (cur_route == RT_OWN);
  assign kill_evt = fire && !mid_q && (hdr_route == RT_KILL);
  assign full_evt = fire && !mid_q && (hdr_route == RT_FULL);
  assign pass_mid = mid_q && (route_q == RT_PASS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q   <= 1'b0;
      route_q <= RT_PASS;
    end else if (fire) begin
      mid_q <= !in_last;
      if (!mid_q) route_q <= hdr_route;
    end
  end
endmodule

// File: rtl/ring_ins_arb.sv
module ring_ins_arb #(
  parameter int SYM_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [SYM_W-1:0] ins_data,
  input  logic             ins_last,
  input  logic             pass_empty,
  input  logic             pass_mid,
  input  logic [SYM_W:0]   pass_beat,
  output logic             pass_rd,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SYM_W-1:0] out_data,
  output logic             out_last
);
  logic claim_q, grant;

  assign grant = claim_q || (ins_valid && pass_empty && !pass_mid);

  always_comb begin
    if (grant) begin
      out_valid = ins_valid;
      out_data  = ins_data;
      out_last  = ins_last;
    end else begin
      out_valid = !pass_empty;
      out_data  = pass_beat[SYM_W-1:0];
      out_last  = pass_beat[SYM_W];
    end
  end

  assign ins_ready = grant && out_ready;
  assign pass_rd   = !grant && !pass_empty && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   claim_q <= 1'b0;
    else if (grant && ins_valid)  claim_q <= !(out_ready && ins_last);
  end
endmodule

// File: rtl/ring_node_bypass.sv
module ring_node_bypass #(
  parameter int SYM_W     = 24,
  parameter int NODE_W    = 16,
  parameter int BYP_DEPTH = 8,
  parameter int RX_DEPTH  = 16,
  parameter int MAX_PKT   = 4,
  parameter int CNT_W     = 16,
  localparam int RCW      = $clog2(RX_DEPTH + 1),
  localparam int BCW      = $clog2(BYP_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NODE_W-1:0] node_base,
  input  logic [NODE_W-1:0] node_mask,
  input  logic              scrub_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SYM_W-1:0]  in_data,
  input  logic              in_last,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [SYM_W-1:0]  ins_data,
  input  logic              ins_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SYM_W-1:0]  out_data,
  output logic              out_last,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [SYM_W-1:0]  rx_data,
  output logic              rx_last,
  output logic [CNT_W-1:0]  drop_mark_cnt,
  output logic [CNT_W-1:0]  drop_full_cnt
);
  logic           pass_wr, own_wr, pass_rd, pass_mid, kill_evt, full_evt;
  logic           pass_full, pass_empty, own_full, own_empty;
  logic [SYM_W:0] beat, pass_beat, own_beat;
  logic [RCW-1:0] own_count;
  logic [BCW-1:0] pass_count;

  ring_route_ctl #(
    .SYM_W(SYM_W), .NODE_W(NODE_W), .RX_DEPTH(RX_DEPTH), .MAX_PKT(MAX_PKT)
  ) u_route (
    .clk(clk), .rst_n(rst_n), .node_base(node_base), .node_mask(node_mask),
    .scrub_en(scrub_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .pass_full(pass_full),
    .own_full(own_full), .own_count(own_count), .pass_wr(pass_wr),
    .own_wr(own_wr), .beat_out(beat), .pass_mid(pass_mid),
    .kill_evt(kill_evt), .full_evt(full_evt)
  );

  ring_sym_fifo #(.W(SYM_W + 1), .DEPTH(BYP_DEPTH)) u_pass_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(pass_wr), .wr_data(beat),
    .rd_en(pass_rd), .rd_data(pass_beat), .count(pass_count),
    .empty(pass_empty), .full(pass_full)
  );

  ring_sym_fifo #(.W(SYM_W + 1), .DEPTH(RX_DEPTH)) u_own_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(own_wr), .wr_data(beat),
    .rd_en(rx_valid && rx_ready), .rd_data(own_beat), .count(own_count),
    .empty(own_empty), .full(own_full)
  );

  assign rx_valid = !own_empty;
  assign rx_data  = own_beat[SYM_W-1:0];
  assign rx_last  = own_beat[SYM_W];

  ring_ins_arb #(.SYM_W(SYM_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_data(ins_data), .ins_last(ins_last), .pass_empty(pass_empty),
    .pass_mid(pass_mid), .pass_beat(pass_beat), .pass_rd(pass_rd),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  ring_sat_cnt #(.W(CNT_W)) u_kill_cnt (
    .clk(clk), .rst_n(rst_n), .bump(kill_evt), .value(drop_mark_cnt)
  );

  ring_sat_cnt #(.W(CNT_W)) u_full_cnt (
    .clk(clk), .rst_n(rst_n), .bump(full_evt), .value(drop_full_cnt)
  );
endmodule

// File: rtl/ring_node_bypass_chk.sv
module ring_node_bypass_chk #(
  parameter int SYM_W = 24,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [SYM_W-1:0] out_data,
  input logic             out_last,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic [SYM_W-1:0] rx_data,
  input logic             rx_last,
  input logic [CNT_W-1:0] drop_mark_cnt,
  input logic [CNT_W-1:0] drop_full_cnt
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R10
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data) && $stable(rx_last)); // R3
  AST_INS_ON_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ready |-> out_valid && out_ready); // R9
  AST_KILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drop_mark_cnt) |-> drop_mark_cnt == $past(drop_mark_cnt) + 1'b1); // R7
  AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drop_full_cnt) |-> drop_full_cnt == $past(drop_full_cnt) + 1'b1); // R5
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (&drop_full_cnt) |=> (&drop_full_cnt)); // R11
endmodule

bind ring_node_bypass ring_node_bypass_chk #(.SYM_W(SYM_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_ready(ins_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
  .drop_mark_cnt(drop_mark_cnt), .drop_full_cnt(drop_full_cnt)
);

// File: tb/ring_node_bypass_bench.sv
module ring_node_bypass_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SYM_W = 24, NODE_W = 16, BYP_DEPTH = 4, RX_DEPTH = 16;
  localparam int MAX_PKT = 4, CNT_W = 3;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0;
  logic [NODE_W-1:0] node_base = 16'h0040, node_mask = 16'hFFF0;
  logic scrub_en = 0;
  logic in_valid = 0, in_last = 0, ins_valid = 0, ins_last = 0;
  logic [SYM_W-1:0] in_data = '0, ins_data = '0;
  logic in_ready, ins_ready, out_valid, out_last, rx_valid, rx_last;
  logic out_ready = 1, rx_ready = 1;
  logic [SYM_W-1:0] out_data, rx_data;
  logic [CNT_W-1:0] drop_mark_cnt, drop_full_cnt;

  ring_node_bypass #(.SYM_W(SYM_W), .NODE_W(NODE_W), .BYP_DEPTH(BYP_DEPTH),
    .RX_DEPTH(RX_DEPTH), .MAX_PKT(MAX_PKT), .CNT_W(CNT_W)) u_ring_node_bypass (
    .clk(clk), .rst_n(rst_n), .node_base(node_base), .node_mask(node_mask),
    .scrub_en(scrub_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .ins_valid(ins_valid),
    .ins_ready(ins_ready), .ins_data(ins_data), .ins_last(ins_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_last(rx_last), .drop_mark_cnt(drop_mark_cnt),
    .drop_full_cnt(drop_full_cnt));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int stall_mode = 0;   // 0 always ready, 1 random, 2 rx stopped
  logic [SYM_W:0] src_in[$], src_ins[$], m_pass[$], m_own[$];
  bit m_mid = 0, m_claim = 0, in_fired = 0, ins_fired = 0, out_sop = 1;
  int m_route = 0, m_kill = 0, m_full = 0, flagged_seen = 0, tagn = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle behavioural reference, evaluated mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      int hdr, cur;
      bit own, go, e_in_rdy, e_ov, ofire;
      logic [SYM_W:0] e_out, b;
      own = (((in_data[15:0] ^ node_base) & node_mask) == 0);
      if (own) hdr = ((RX_DEPTH - m_own.size()) >= MAX_PKT) ? 1 : 3;
      else if (scrub_en && in_data[16]) hdr = 2;
      else hdr = 0;
      cur = m_mid ? m_route : hdr;
      e_in_rdy = (cur == 0) ? (m_pass.size() < BYP_DEPTH) :
                 (cur == 1) ? (m_own.size() < RX_DEPTH) : 1'b1;
      go = m_claim || (ins_valid && m_pass.size() == 0 && !(m_mid && m_route == 0));
      e_ov = go ? ins_valid : (m_pass.size() > 0);
      e_out = go ? {ins_last, ins_data} : (m_pass.size() > 0 ? m_pass[0] : '0);
      if (in_valid) chk(in_ready == e_in_rdy, "R10", "in_ready", in_ready, e_in_rdy);
      chk(out_valid == e_ov, "R9", "out_valid", out_valid, e_ov);
      if (e_ov) chk({out_last, out_data} == e_out, "R4", "out beat",
                    {out_last, out_data}, e_out);
      chk(ins_ready == (go && out_ready), "R9", "ins_ready", ins_ready, go && out_ready);
      chk(rx_valid == (m_own.size() > 0), "R3", "rx_valid", rx_valid, m_own.size() > 0);
      if (m_own.size() > 0) chk({rx_last, rx_data} == m_own[0], "R3", "rx beat",
                               {rx_last, rx_data}, m_own[0]);
      chk(drop_mark_cnt == m_kill, "R7", "drop_mark_cnt", drop_mark_cnt, m_kill);
      chk(drop_full_cnt == m_full, "R5", "drop_full_cnt", drop_full_cnt, m_full);
      // advance model
      ofire = e_ov && out_ready;
      ins_fired = go && ins_valid && out_ready;
      if (ofire) begin
        if (out_sop && out_data[16]) flagged_seen++;
        out_sop = out_last;
        if (!go) void'(m_pass.pop_front());
      end
      if (go && ins_valid) m_claim = !(out_ready && ins_last);
      if (m_own.size() > 0 && rx_ready) void'(m_own.pop_front());
      in_fired = in_valid && e_in_rdy;
      if (in_fired) begin
        b = {in_last, in_data};
        if (cur == 0) begin
          if (!m_mid && scrub_en) b[16] = 1'b1;
          m_pass.push_back(b);
        end else if (cur == 1) m_own.push_back(b);
        if (!m_mid && hdr == 2 && m_kill < CMAX) m_kill++;
        if (!m_mid && hdr == 3 && m_full < CMAX) m_full++;
        if (!m_mid) m_route = hdr;
        m_mid = !in_last;
      end
    end
  end

  task automatic add_pkt(input logic [15:0] dest, input bit flag, input int len,
                         input bit local_src);
    tagn++;
    for (int i = 0; i < len; i++) begin
      logic [SYM_W:0] s;
      if (i == 0) s = {len == 1, tagn[6:0], flag, dest};
      else s = {i == len - 1, SYM_W'(tagn * 97 + i * 13)};
      if (local_src) src_ins.push_back(s); else src_in.push_back(s);
    end
  endtask

  task automatic drain();
    stall_mode = (stall_mode == 2) ? 0 : stall_mode;
    while (src_in.size() || src_ins.size() || m_pass.size() || m_own.size() || m_claim)
      @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic run_all();
    // R1: reset state
    #(CLK_PERIOD * 3);
    chk(!out_valid && !rx_valid && !ins_ready, "R1", "valids in reset",
        {out_valid, rx_valid, ins_ready}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(drop_mark_cnt == 0 && drop_full_cnt == 0, "R1", "counters after reset",
        {drop_mark_cnt, drop_full_cnt}, 0);
    // R2 R3 R4 R8: mixed owned/foreign, scrub off, flagged foreign passes
    add_pkt(16'h0043, 0, 3, 0);
    add_pkt(16'h1234, 0, 2, 0);
    add_pkt(16'h004F, 1, 1, 0);
    add_pkt(16'h0053, 1, 4, 0);
    add_pkt(16'h0040, 0, 2, 0);
    drain();
    chk(flagged_seen == 1, "R8", "flagged headers forwarded", flagged_seen, 1);
    // R9 R10: random stalls with local insertion competing
    stall_mode = 1;
    for (int k = 0; k < 40; k++) begin
      add_pkt((k % 3 == 0) ? 16'h0041 : 16'h2000 + k, 0, 1 + k % 5, 0);
      if (k % 4 == 0) add_pkt(16'h7000 + k, 0, 1 + k % 3, 1);
    end
    drain();
    stall_mode = 0;
    // R5 R11: receive queue full
    stall_mode = 2;
    for (int k = 0; k < 5; k++) add_pkt(16'h0044, 0, 4, 0);
    while (src_in.size()) @(posedge clk);
    repeat (3) @(posedge clk);
    chk(drop_full_cnt == 1, "R5", "full drops after 5 packets", drop_full_cnt, 1);
    for (int k = 0; k < 8; k++) add_pkt(16'h0045, 0, 2, 0);
    while (src_in.size()) @(posedge clk);
    repeat (3) @(posedge clk);
    chk(drop_full_cnt == CMAX, "R11", "full counter saturated", drop_full_cnt, CMAX);
    drain();
    // R6 R7: scrubber
    scrub_en = 1; flagged_seen = 0;
    add_pkt(16'h3000, 1, 3, 0);
    add_pkt(16'h3001, 0, 2, 0);
    add_pkt(16'h3002, 1, 1, 0);
    add_pkt(16'h0046, 1, 2, 0);
    add_pkt(16'h3003, 0, 1, 0);
    add_pkt(16'h3004, 1, 2, 0);
    drain();
    chk(drop_mark_cnt == 3, "R7", "orphans removed", drop_mark_cnt, 3);
    chk(flagged_seen == 2, "R6", "forwarded headers flagged", flagged_seen, 2);
    scrub_en = 0;
  endtask

  // stimulus driver: updates inputs just after each rising edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (in_fired) begin void'(src_in.pop_front()); in_fired = 0; end
      if (ins_fired) begin void'(src_ins.pop_front()); ins_fired = 0; end
      in_valid = src_in.size() > 0;
      {in_last, in_data} = in_valid ? src_in[0] : '0;
      ins_valid = src_ins.size() > 0;
      {ins_last, ins_data} = ins_valid ? src_ins[0] : '0;
      out_ready = (stall_mode == 1) ? ($urandom_range(0, 2) != 0) : 1'b1;
      rx_ready  = (stall_mode == 1) ? ($urandom_range(0, 1) != 0) :
                  (stall_mode == 2) ? 1'b0 : 1'b1;
    end
  end

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        chk(0, "R1", "watchdog expired", 1, 0);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule